// File: doc/BRIEF.md
# Audio Serial Transmitter (Two-Channel, Frame-Clocked)

This block sends 16-bit audio samples out as a two-channel serial stream. It makes its own bit clock and its own channel-select (word-select) line, and it drives one serial data line. Samples arrive through a single-word write port and wait in an 8-entry output queue. The bit clock comes from an 8-bit divide count that runs on clock-enable ticks. Those ticks come from one of two tick inputs, which stand for two possible timebases inside one synchronous clock domain.

Configuration is written through a strobe. It covers four choices: the bit-clock edge on which data is launched, which channel is sent while word-select is high, stereo or mono packing, and the tick source. It also sets the bit-clock divide value and a minimum half-frame length in bits. The configuration register accepts writes only while both the clock-generator enable and the transmit enable are low. Dropping transmit enable empties the queue.

A frame always opens with word-select driven high. Each half-frame carries one sample, most significant bit first, followed by zero padding when the half-frame is longer than 16 bits. When the queue cannot supply a full frame, a frame of zeros is sent and the framing timing carries on.

Top module: `audio_ser_tx`

## Requirements
- R1: The divide counter advances only on ticks of the selected source (`cfg_src_b`=0 selects `tick_a`, 1 selects `tick_b`). The bit clock toggles once every `cfg_div`+1 selected ticks, and the output changes in the clock cycle after the tick that completes the half period.
- R2: While `clkgen_en` is 0, the outputs are held in the cycle after the edge as follows: `bclk` at its idle level (1 when `cfg_edge`=0, 0 when `cfg_edge`=1), `wsel` at 0 and `sdata` at 0. The divide count restarts from zero when `clkgen_en` is raised.
- R3: `sdata` and `wsel` change only in the cycle in which `bclk` moves to its launch level. The launch level is 0 (falling) when `cfg_edge`=0 and 1 (rising) when `cfg_edge`=1. The opposite bclk edge is the sampling edge.
- R4: With both enables high, the first launch edge starts a frame with `wsel`=1. Each `wsel` level lasts L bit periods, where L = `cfg_wslen` when that value exceeds 16 and L = 16 otherwise. Each half-frame sends its 16-bit sample MSB first and then L-16 zero bits.
- R5: With `cfg_left_hi`=1 the left sample is sent while `wsel` is high. With `cfg_left_hi`=0 the right sample is sent while `wsel` is high.
- R6: In stereo (`cfg_mono`=0), a frame start takes two queue entries: the older entry is the left sample and the next entry is the right sample.
- R7: In mono (`cfg_mono`=1), a frame start takes one queue entry and sends it in both half-frames.
- R8: A frame start that finds fewer entries than the mode needs (2 in stereo, 1 in mono) takes none and sends zeros for that whole frame, while `wsel` keeps its timing.
- R9: The queue holds 8 samples. A write (`wr_en`) that finds it holding 8 is dropped.
- R10: `q_empty` is 1 exactly when the queue holds no entries. It updates in the cycle after the accepting write edge or after the edge at which the last entry is taken.
- R11: While `tx_en` is 0, the queue is emptied and writes are dropped.
- R12: A configuration write (`cfg_wr`) takes effect at the next edge only when `clkgen_en` and `tx_en` are both 0. At any other time it is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_a | input | 1 | Timebase tick, source A |
| tick_b | input | 1 | Timebase tick, source B |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_edge | input | 1 | 0: launch on falling bclk, 1: launch on rising bclk |
| cfg_left_hi | input | 1 | 1: left sample while wsel high, 0: right sample |
| cfg_mono | input | 1 | 0: stereo, 1: mono |
| cfg_src_b | input | 1 | 0: tick_a timebase, 1: tick_b timebase |
| cfg_div | input | 8 | Bit-clock half-period minus one, in ticks |
| cfg_wslen | input | 6 | Requested half-frame length in bits (minimum 16 applied) |
| clkgen_en | input | 1 | Clock-generator enable |
| tx_en | input | 1 | Transmit enable; low flushes the queue |
| wr_en | input | 1 | Sample write strobe |
| wr_data | input | 16 | Sample word |
| bclk | output | 1 | Generated bit clock |
| wsel | output | 1 | Word-select output |
| sdata | output | 1 | Serial data output |
| q_empty | output | 1 | Queue empty flag |

## Verification
All outputs are registered, so each result is due exactly one clock cycle after the edge that causes it. `bclk`, `wsel` and `sdata` move together in the cycle after the tick that ends a half period. `q_empty` and a new configuration take effect one edge after the write or flush. The bench keeps a behavioural model that updates at the same edge from the same pre-edge inputs. It compares all four outputs 2 ns after every rising edge and changes inputs only on falling edges, so every comparison falls in the cycle in which a result is due.

// File: rtl/ast_pkg.sv
// Shared widths and the configuration record for the serial audio transmitter.
// Assumes one clock domain; all timebases arrive as clock-enable ticks.
package ast_pkg;
    localparam int SAMPLE_W = 16;   // bits per sample
    localparam int DIV_W    = 8;    // bit-clock divide field width
    localparam int WSL_W    = 6;    // half-frame length field width
    localparam int Q_DEPTH  = 8;    // output queue entries

    typedef struct packed {
        logic             edge_rise;  // launch on rising bclk
        logic             left_hi;    // left sample during wsel high
        logic             mono;       // one entry per frame
        logic             src_b;      // timebase select
        logic [DIV_W-1:0] div;        // half period minus one, in ticks
        logic [WSL_W-1:0] wslen;      // requested half-frame bits
    } txcfg_t;
endpackage

// File: rtl/ast_bclk_gen.sv
// Bit-clock generator: counts selected ticks and toggles bclk every div+1 ticks.
// Reports a launch strobe in the cycle whose edge moves bclk to the launch level.
// Assumes run low holds the count at zero and parks bclk at idle_lvl.
module ast_bclk_gen #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             tick,
    input  logic             edge_rise,
    input  logic [DIV_W-1:0] div,
    output logic             bclk,
    output logic             launch
);
    logic [DIV_W-1:0] cnt_q;
    logic             bclk_q;
    logic             wrap;

    // terminal count on a tick ends the half period
    assign wrap   = run && tick && (cnt_q == div);
    // the toggle lands on the launch level
    assign launch = wrap && ((~bclk_q) == edge_rise);
    assign bclk   = bclk_q;

    // divide counter and bit-clock level
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= '0;
            bclk_q <= 1'b1;
        end else if (!run) begin
            cnt_q  <= '0;
            bclk_q <= ~edge_rise;
        end else if (tick) begin
            if (wrap) begin
                cnt_q  <= '0;
                bclk_q <= ~bclk_q;
            end else begin
                cnt_q  <= cnt_q + DIV_W'(1);
            end
        end
    end
endmodule

// File: rtl/ast_fifo.sv
// Output sample queue with two-entry look-ahead and a 0/1/2 pop count.
// Assumes DEPTH is a power of two, pop_cnt never exceeds level, and
// flush has priority over push and pop.
module ast_fifo #(
    parameter int W     = 16,
    parameter int DEPTH = 8,
    localparam int AW   = $clog2(DEPTH),
    localparam int LW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          push,
    input  logic [W-1:0]  din,
    input  logic [1:0]    pop_cnt,
    output logic [W-1:0]  head0,
    output logic [W-1:0]  head1,
    output logic [LW-1:0] level
);
    logic [W-1:0]  mem [DEPTH];
    logic [AW-1:0] rd_ptr, wr_ptr;
    logic [LW-1:0] level_q;
    logic          push_ok;

    assign push_ok = push && !flush && (level_q < LW'(DEPTH));
    assign head0   = mem[rd_ptr];
    assign head1   = mem[rd_ptr + AW'(1)];
    assign level   = level_q;

    // storage write
    always_ff @(posedge clk) begin
        if (push_ok) begin
            mem[wr_ptr] <= din;
        end
    end

    // pointers and fill level
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            rd_ptr  <= '0;
            wr_ptr  <= '0;
            level_q <= '0;
        end else begin
            rd_ptr  <= rd_ptr + AW'(pop_cnt);
            wr_ptr  <= wr_ptr + AW'(push_ok);
            level_q <= level_q - LW'(pop_cnt) + LW'(push_ok);
        end
    end
endmodule

// File: rtl/ast_framer.sv
// Frame serializer: on each launch strobe shifts one bit out, switches wsel at
// half-frame ends and fetches a sample pair from the queue at frame starts.
// Assumes the queue look-ahead is valid whenever level covers the entries read.
module ast_framer #(
    parameter int SW    = 16,
    parameter int WSL_W = 6,
    parameter int LW    = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          run,
    input  logic          launch,
    input  logic          mono,
    input  logic          left_hi,
    input  logic [WSL_W-1:0] wslen,
    input  logic [LW-1:0] level,
    input  logic [SW-1:0] head0,
    input  logic [SW-1:0] head1,
    output logic [1:0]    pop_cnt,
    output logic          wsel,
    output logic          sdata
);
    logic             started, slot_hi_done;
    logic [WSL_W-1:0] bit_q, last_bit;
    logic [SW-1:0]    shreg, hold;
    logic             ws_q, sd_q;
    logic             slot_end, frame_go, slot_go, have;
    logic [SW-1:0]    left_s, right_s, first_s, second_s;

    // half-frame length: at least one full sample
    assign last_bit = (wslen > WSL_W'(SW)) ? (wslen - WSL_W'(1)) : WSL_W'(SW - 1);
    assign slot_end = started && (bit_q == last_bit);
    assign frame_go = run && launch && (!started || (slot_end && slot_hi_done));
    assign slot_go  = run && launch && slot_end && !slot_hi_done;

    // sample pair selection for a frame start
    always_comb begin
        have     = mono ? (level >= LW'(1)) : (level >= LW'(2));
        left_s   = have ? head0 : '0;
        right_s  = have ? (mono ? head0 : head1) : '0;
        first_s  = left_hi ? left_s  : right_s;
        second_s = left_hi ? right_s : left_s;
        pop_cnt  = (frame_go && have) ? (mono ? 2'd1 : 2'd2) : 2'd0;
    end

    assign wsel  = ws_q;
    assign sdata = sd_q;

    // frame state, shift register and line outputs
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            started      <= 1'b0;
            slot_hi_done <= 1'b0;
            bit_q        <= '0;
            shreg        <= '0;
            hold         <= '0;
            ws_q         <= 1'b0;
            sd_q         <= 1'b0;
        end else if (launch) begin
            if (frame_go) begin
                started      <= 1'b1;
                slot_hi_done <= 1'b0;
                bit_q        <= '0;
                ws_q         <= 1'b1;
                sd_q         <= first_s[SW-1];
                shreg        <= first_s << 1;
                hold         <= second_s;
            end else if (slot_go) begin
                slot_hi_done <= 1'b1;
                bit_q        <= '0;
                ws_q         <= 1'b0;
                sd_q         <= hold[SW-1];
                shreg        <= hold << 1;
            end else begin
                bit_q        <= bit_q + WSL_W'(1);
                sd_q         <= shreg[SW-1];
                shreg        <= shreg << 1;
            end
        end
    end
endmodule

// File: rtl/audio_ser_tx.sv
// Serial audio transmitter top: holds the locked configuration register,
// selects the timebase tick and joins the bit-clock generator, the sample
// queue and the frame serializer. Assumes all ticks are synchronous to clk.
module audio_ser_tx
    import ast_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tick_a,
    input  logic                tick_b,
    input  logic                cfg_wr,
    input  logic                cfg_edge,
    input  logic                cfg_left_hi,
    input  logic                cfg_mono,
    input  logic                cfg_src_b,
    input  logic [DIV_W-1:0]    cfg_div,
    input  logic [WSL_W-1:0]    cfg_wslen,
    input  logic                clkgen_en,
    input  logic                tx_en,
    input  logic                wr_en,
    input  logic [SAMPLE_W-1:0] wr_data,
    output logic                bclk,
    output logic                wsel,
    output logic                sdata,
    output logic                q_empty
);
    localparam int LW = $clog2(Q_DEPTH + 1);

    txcfg_t              cfg_q;
    logic                tick_sel, launch;
    logic [1:0]          pop_cnt;
    logic [LW-1:0]       fill_lvl;
    logic [SAMPLE_W-1:0] head0, head1;

    // configuration register, writable only with both enables low
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else if (cfg_wr && !clkgen_en && !tx_en) begin
            cfg_q <= '{edge_rise: cfg_edge, left_hi: cfg_left_hi, mono: cfg_mono,
                       src_b: cfg_src_b, div: cfg_div, wslen: cfg_wslen};
        end
    end

    assign tick_sel = cfg_q.src_b ? tick_b : tick_a;
    assign q_empty  = (fill_lvl == '0);

    ast_bclk_gen #(.DIV_W(DIV_W)) u_bclk (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (clkgen_en),
        .tick      (tick_sel),
        .edge_rise (cfg_q.edge_rise),
        .div       (cfg_q.div),
        .bclk      (bclk),
        .launch    (launch)
    );

    ast_fifo #(.W(SAMPLE_W), .DEPTH(Q_DEPTH)) u_fifo (
        .clk     (clk),
        .rst_n   (rst_n),
        .flush   (!tx_en),
        .push    (wr_en),
        .din     (wr_data),
        .pop_cnt (pop_cnt),
        .head0   (head0),
        .head1   (head1),
        .level   (fill_lvl)
    );

    ast_framer #(.SW(SAMPLE_W), .WSL_W(WSL_W), .LW(LW)) u_framer (
        .clk     (clk),
        .rst_n   (rst_n),
        .run     (clkgen_en && tx_en),
        .launch  (launch),
        .mono    (cfg_q.mono),
        .left_hi (cfg_q.left_hi),
        .wslen   (cfg_q.wslen),
        .level   (fill_lvl),
        .head0   (head0),
        .head1   (head1),
        .pop_cnt (pop_cnt),
        .wsel    (wsel),
        .sdata   (sdata)
    );
endmodule

// Property checker for audio_ser_tx, attached by bind below.
// Assumes it sees the top's ports plus its fill level and configuration bits.
module audio_ser_tx_chk #(
    parameter int DEPTH = 8,
    parameter int LW    = 4,
    parameter int CW    = 18
) (
    input logic          clk,
    input logic          rst_n,
    input logic          clkgen_en,
    input logic          tx_en,
    input logic          wr_en,
    input logic          bclk,
    input logic          wsel,
    input logic          sdata,
    input logic          q_empty,
    input logic          launch_lvl,
    input logic [LW-1:0] fill_lvl,
    input logic [CW-1:0] cfg_bits
);
    // R2
    idle_lines_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clkgen_en |=> (bclk == !$past(launch_lvl)) && !wsel && !sdata);
    // R3
    ws_on_launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(wsel) && $past(clkgen_en) && $past(tx_en)) |-> (!$stable(bclk) && bclk == launch_lvl));
    // R3
    sd_on_launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(sdata) && $past(clkgen_en) && $past(tx_en)) |-> (!$stable(bclk) && bclk == launch_lvl));
    // R9
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fill_lvl <= LW'(DEPTH));
    // R10
    write_clears_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && tx_en && q_empty) |=> !q_empty);
    // R11
    flush_empties_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tx_en |=> (fill_lvl == '0));
    // R12
    cfg_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clkgen_en || tx_en) |=> $stable(cfg_bits));
endmodule

bind audio_ser_tx audio_ser_tx_chk #(
    .DEPTH (ast_pkg::Q_DEPTH),
    .LW    ($clog2(ast_pkg::Q_DEPTH + 1)),
    .CW    ($bits(ast_pkg::txcfg_t))
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .clkgen_en  (clkgen_en),
    .tx_en      (tx_en),
    .wr_en      (wr_en),
    .bclk       (bclk),
    .wsel       (wsel),
    .sdata      (sdata),
    .q_empty    (q_empty),
    .launch_lvl (cfg_q.edge_rise),
    .fill_lvl   (fill_lvl),
    .cfg_bits   (cfg_q)
);

// File: tb/audio_ser_tx_test.sv
// Bench for audio_ser_tx: a behavioural model (queue, integers) is stepped at
// every rising edge from the same inputs and compared with the outputs 2 ns later.
module audio_ser_tx_test;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick_a = 1'b1, tick_b = 1'b0;
    logic cfg_wr = 1'b0, cfg_edge = 1'b0, cfg_left_hi = 1'b0, cfg_mono = 1'b0, cfg_src_b = 1'b0;
    logic [7:0] cfg_div = '0;
    logic [5:0] cfg_wslen = '0;
    logic clkgen_en = 1'b0, tx_en = 1'b0, wr_en = 1'b0;
    logic [15:0] wr_data = '0;
    logic bclk, wsel, sdata, q_empty;

    int n_tests = 0, n_fail = 0, cyc = 0, alt_cnt = 0;
    string tag = "R2 reset";

    always #4 clk = ~clk;   // 125 MHz

    audio_ser_tx uut (.*);

    // model state
    bit m_edge, m_lf, m_mono, m_alt;
    int m_div, m_wsl, m_cnt, m_bit, m_last, qn;
    bit m_sck, m_started, m_slot, m_ws, m_sdo, tk, launch, have;
    logic [15:0] m_sh, m_hold, ls, rs, fs, ss;
    logic [15:0] q[$];

    // reference model step
    always @(posedge clk) begin
        if (!rst_n) begin
            m_edge = 0; m_lf = 0; m_mono = 0; m_alt = 0; m_div = 0; m_wsl = 0;
            m_cnt = 0; m_sck = 1; m_started = 0; m_slot = 0; m_bit = 0;
            m_ws = 0; m_sdo = 0; m_sh = 0; m_hold = 0; q.delete();
        end else begin
            tk = m_alt ? tick_b : tick_a;
            launch = 0;
            qn = q.size();
            if (!clkgen_en) begin
                m_cnt = 0; m_sck = !m_edge;
            end else if (tk) begin
                if (m_cnt == m_div) begin
                    m_cnt = 0; m_sck = !m_sck; launch = (m_sck == m_edge);
                end else m_cnt = m_cnt + 1;
            end
            if (!(clkgen_en && tx_en)) begin
                m_started = 0; m_slot = 0; m_bit = 0; m_ws = 0; m_sdo = 0; m_sh = 0; m_hold = 0;
            end else if (launch) begin
                m_last = (m_wsl > 16) ? m_wsl - 1 : 15;
                if (!m_started || (m_bit == m_last && m_slot)) begin
                    have = m_mono ? (qn >= 1) : (qn >= 2);
                    ls = 0; rs = 0;
                    if (have) begin
                        ls = q.pop_front();
                        rs = m_mono ? ls : q.pop_front();
                    end
                    fs = m_lf ? ls : rs; ss = m_lf ? rs : ls;
                    m_started = 1; m_slot = 0; m_bit = 0; m_ws = 1;
                    m_sdo = fs[15]; m_sh = fs << 1; m_hold = ss;
                end else if (m_bit == m_last) begin
                    m_slot = 1; m_bit = 0; m_ws = 0; m_sdo = m_hold[15]; m_sh = m_hold << 1;
                end else begin
                    m_bit = m_bit + 1; m_sdo = m_sh[15]; m_sh = m_sh << 1;
                end
            end
            if (!tx_en) q.delete();
            else if (wr_en && qn < 8) q.push_back(wr_data);
            if (cfg_wr && !clkgen_en && !tx_en) begin
                m_edge = cfg_edge; m_lf = cfg_left_hi; m_mono = cfg_mono; m_alt = cfg_src_b;
                m_div = int'(cfg_div); m_wsl = int'(cfg_wslen);
            end
        end
    end

    task automatic chk(input string what, input logic got, input logic exp);
        n_tests++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s [%s] cycle %0d: actual %b expected %b", what, tag, cyc, got, exp);
        end
    endtask

    // per-cycle comparison, away from the edge
    always @(posedge clk) begin
        cyc++;
        #2;
        if (rst_n) begin
            chk("bclk", bclk, m_sck);
            chk("wsel", wsel, m_ws);
            chk("sdata", sdata, m_sdo);
            chk("q_empty", q_empty, (q.size() == 0));
        end
    end

    // source-B tick: one in three cycles
    always @(negedge clk) begin
        alt_cnt = (alt_cnt + 1) % 3;
        tick_b <= (alt_cnt == 0);
    end

    task automatic set_cfg(input bit e, input bit lf, input bit mo, input bit sb,
                           input logic [7:0] dv, input logic [5:0] wl);
        @(negedge clk);
        cfg_wr = 1; cfg_edge = e; cfg_left_hi = lf; cfg_mono = mo; cfg_src_b = sb;
        cfg_div = dv; cfg_wslen = wl;
        @(negedge clk);
        cfg_wr = 0;
    endtask

    task automatic put(input logic [15:0] v);
        @(negedge clk);
        wr_en = 1; wr_data = v;
        @(negedge clk);
        wr_en = 0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic stop_all();
        @(negedge clk);
        clkgen_en = 0; tx_en = 0;
        idle(3);
    endtask

    // watchdog
    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog [all] actual timeout expected finish");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        idle(3);
        @(negedge clk); rst_n = 1;
        @(negedge clk);
        // R2 R10: reset state
        tag = "R2 R10 reset";
        n_tests++; if (!(bclk === 1 && wsel === 0 && sdata === 0 && q_empty === 1)) begin
            n_fail++; $display("FAIL reset [R2 R10] actual %b%b%b%b expected 1001", bclk, wsel, sdata, q_empty);
        end

        // stereo, left high, launch on falling, source A, div 1, 16-bit halves
        tag = "R1 R3 R4 R5 R6 R8 R10 R11";
        set_cfg(0, 1, 0, 0, 8'd1, 6'd0);
        @(negedge clk) tx_en = 1;
        put(16'hA5C3); put(16'h1234); put(16'hFFFF); put(16'h8001); put(16'h0F0F);
        @(negedge clk) clkgen_en = 1;
        idle(420);
        // R11 R10: flush with one entry left
        n_tests++; if (q_empty !== 0) begin
            n_fail++; $display("FAIL leftover [R8 R10] actual %b expected 0", q_empty);
        end
        @(negedge clk) tx_en = 0;
        @(negedge clk);
        n_tests++; if (q_empty !== 1) begin
            n_fail++; $display("FAIL flush [R11] actual %b expected 1", q_empty);
        end
        stop_all();

        // R11: writes with tx disabled are dropped
        tag = "R11 R2";
        put(16'h7777);
        n_tests++; if (q_empty !== 1) begin
            n_fail++; $display("FAIL drop-when-off [R11] actual %b expected 1", q_empty);
        end

        // mono, right high, launch on rising, source B, div 0, 20-bit halves, 9 writes
        tag = "R1 R3 R4 R7 R9 R12";
        set_cfg(1, 0, 1, 1, 8'd0, 6'd20);
        @(negedge clk) tx_en = 1;
        for (int i = 0; i < 9; i++) put(16'h1111 * 16'(i + 1) ^ 16'h8421);
        n_tests++; if (q_empty !== 0) begin
            n_fail++; $display("FAIL loaded [R10] actual %b expected 0", q_empty);
        end
        @(negedge clk) clkgen_en = 1;
        idle(300);
        // R12: write while running is ignored
        set_cfg(0, 1, 0, 0, 8'd5, 6'd2);
        idle(2000);
        stop_all();

        // stereo, right high, launch on falling, div 2, short wslen -> 16
        tag = "R4 R5 R6 R2";
        set_cfg(0, 0, 0, 0, 8'd2, 6'd10);
        idle(4);
        @(negedge clk) tx_en = 1;
        put(16'hC001); put(16'h00FE); put(16'h5A5A); put(16'h3C3C);
        @(negedge clk) clkgen_en = 1;
        idle(700);
        // R1: source A ticks paused freeze bclk
        tag = "R1 tick gating";
        @(negedge clk) tick_a = 0;
        idle(20);
        @(negedge clk) tick_a = 1;
        idle(50);
        stop_all();

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule